// File: doc/BRIEF.md
# Card Socket Status Input Port

This block watches the eight status lines of a removable-card socket. Each line is brought into the system clock domain by a synchronizer, compared with its own value one clock earlier, and any detected change latches a sticky per-line flag. Software reads the synchronized levels and the flags through a small register interface. It clears flags by writing ones, and it picks which flags may raise the single interrupt output.

Beside the generic port behaviour, the block decodes the fixed roles of the socket lines. Two active-low detect lines qualify card presence, and one line reports write protection. Two battery lines give a three-level condition. In I/O mode the first battery line is reread as a status-change request. Line 7 alone can be set to flag only rising edges, only falling edges, or both. The remaining lines flag every change.

Registers are selected by a 2-bit address. Reads are combinational and writes take effect on the next rising clock edge. Address 0 is status (read only), 1 is change flags, 2 is interrupt enables, and 3 is the line-7 edge selection.

Top module: `card_stat_port`

## Requirements
- R1: Register address 0 returns the synchronized line levels in bits 23:16 (line 0 in bit 16), with all other bits zero. A line change shows there on the second rising edge after it is applied. Writes to address 0 have no effect.
- R2: A change on any of lines 0 to 6 sets the matching bit of the flag register (address 1, bits 7:0) on the third rising edge after the change is applied. Flags stay set until cleared.
- R3: Writing address 1 clears each flag whose data bit is 1 and leaves the others. When a new edge on a line is detected in the same cycle as a clear of its flag, the flag stays set.
- R4: Address 3 bits 1:0 select the line-7 edge kind: 0 or 3 flags both edges, 1 flags only a low-to-high change, and 2 flags only a high-to-low change.
- R5: Address 2 bits 7:0 are the interrupt enables. irq_o is high exactly when some flag is set whose enable bit is 1. It falls only after a register write.
- R6: After reset, flags, enables and the line-7 selection (both edges) are zero. No flag is set by the line levels present during or at the end of reset.
- R7: card_present_o is high only when both synchronized lines 3 and 4 are low.
- R8: In memory mode (io_mode_i low), batt_state_o is 0 (good) when lines 5 and 6 are both low. It is 1 (warning) when line 6 is high and line 5 is low. It is 2 (dead) whenever line 5 is high.
- R9: In I/O mode batt_state_o is 3 (not applicable) and stschg_o is the inverse of synchronized line 5. stschg_evt_o pulses for exactly one cycle when synchronized line 5 falls, on the second rising edge after the change.
- R10: write_prot_o equals synchronized line 2, where high means protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 8 | Asynchronous socket status lines |
| io_mode_i | input | 1 | 1 = I/O interface mode, 0 = memory mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request, level |
| card_present_o | output | 1 | Both detect lines asserted |
| write_prot_o | output | 1 | Card write protected |
| batt_state_o | output | 2 | Battery condition code |
| stschg_o | output | 1 | Status-change level in I/O mode |
| stschg_evt_o | output | 1 | One-cycle status-change assertion event |

## Verification
The assertions assume that reset is held for at least two clock cycles. This lets the synchronizer preload settle before any check can see the flag history. They also assume that every line change is held long enough to pass through the synchronizer as one clean step. The stimulus holds each new line pattern for four cycles before the next one and keeps reset low for several cycles. It mixes random line patterns, random clear masks, enable masks, mode and edge selections with directed cases for the reset preload, a clear colliding with an edge, and the status-change pulse.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    EDGE_BOTH = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH_ALT = 2'd3
  } edge_sel_e;

  typedef enum logic [1:0] {
    BATT_GOOD = 2'd0,
    BATT_WARN = 2'd1,
    BATT_DEAD = 2'd2,
    BATT_NA   = 2'd3
  } batt_e;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_FLAGS  = 2'd1;
  localparam logic [1:0] A_ENABLE = 2'd2;
  localparam logic [1:0] A_EDGE   = 2'd3;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage1, stage2, stage3;

  // reset preloads every stage with the live pins so no edge appears at release
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= pins_i;
      stage2 <= pins_i;
      stage3 <= pins_i;
    end else begin
      stage1 <= pins_i;
      stage2 <= stage1;
      stage3 <= stage2;
    end
  end

  assign lvl_o  = stage2;
  assign prev_o = stage3;
endmodule

// File: rtl/cs_edge.sv
module cs_edge
  import cs_pkg::*;
#(
  parameter int W    = 8,
  parameter int XPIN = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] prev_i,
  input  edge_sel_e    xsel_i,
  output logic [W-1:0] det_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == XPIN) begin : g_ext
      always_comb begin
        unique case (xsel_i)
          EDGE_RISE: det_o[i] = lvl_i[i] & ~prev_i[i];
          EDGE_FALL: det_o[i] = ~lvl_i[i] & prev_i[i];
          default:   det_o[i] = lvl_i[i] ^ prev_i[i];
        endcase
      end
    end else begin : g_any
      assign det_o[i] = lvl_i[i] ^ prev_i[i];
    end
  end

  // R4: in rising-only selection a line-7 detection means the line is now high
  assert_pin7_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xsel_i == EDGE_RISE && det_o[XPIN]) |-> lvl_i[XPIN]);
  assert_pin7_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xsel_i == EDGE_FALL && det_o[XPIN]) |-> !lvl_i[XPIN]);
endmodule

// File: rtl/cs_flags.sv
module cs_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] det_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] flags_o,
  output logic         irq_o
);
  logic [W-1:0] flags_q;

  // a fresh detection wins over a clear of the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | det_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);

  // R2/R3: every detection is latched on the next edge, clear or not
  assert_edge_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|det_i) |=> ((flags_q & $past(det_i)) == $past(det_i)));
  // R6: a flag only appears where a detection preceded it
  assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q) & ~$past(det_i)) == '0));
endmodule

// File: rtl/cs_decode.sv
module cs_decode
  import cs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  io_mode_i,
  input  logic  wp_lvl_i,
  input  logic  cd_a_lvl_i,
  input  logic  cd_b_lvl_i,
  input  logic  bv1_lvl_i,
  input  logic  bv1_det_i,
  input  logic  bv2_lvl_i,
  output logic  card_present_o,
  output logic  write_prot_o,
  output batt_e batt_state_o,
  output logic  stschg_o,
  output logic  stschg_evt_o
);
  assign card_present_o = ~cd_a_lvl_i & ~cd_b_lvl_i;
  assign write_prot_o   = wp_lvl_i;

  always_comb begin
    if (io_mode_i)      batt_state_o = BATT_NA;
    else if (bv1_lvl_i) batt_state_o = BATT_DEAD;
    else if (bv2_lvl_i) batt_state_o = BATT_WARN;
    else                batt_state_o = BATT_GOOD;
  end

  assign stschg_o     = io_mode_i & ~bv1_lvl_i;
  assign stschg_evt_o = io_mode_i & bv1_det_i & ~bv1_lvl_i;

  // R9: an event pulse always coincides with the asserted level and lasts one cycle
  assert_stschg_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stschg_evt_o |-> stschg_o);
  assert_stschg_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stschg_evt_o |=> !stschg_evt_o);
endmodule

// File: rtl/card_stat_port.sv
module card_stat_port
  import cs_pkg::*;
#(
  parameter int W       = 8,
  parameter int DW      = 32,
  parameter int LVL_LSB = 16,
  parameter int XPIN    = 7,
  parameter int P_WP    = 2,
  parameter int P_CDA   = 3,
  parameter int P_CDB   = 4,
  parameter int P_BV1   = 5,
  parameter int P_BV2   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    pins_i,
  input  logic          io_mode_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          irq_o,
  output logic          card_present_o,
  output logic          write_prot_o,
  output logic [1:0]    batt_state_o,
  output logic          stschg_o,
  output logic          stschg_evt_o
);
  localparam int SELW = 2;

  logic [W-1:0] lvl, prev, det, flags, clr;
  logic [W-1:0] en_q;
  edge_sel_e    xsel_q;
  batt_e        batt;
  logic         unused_wbits;

  assign unused_wbits = ^reg_wdata_i[DW-1:W];

  cs_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .lvl_o(lvl), .prev_o(prev)
  );

  cs_edge #(.W(W), .XPIN(XPIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .prev_i(prev), .xsel_i(xsel_q), .det_o(det)
  );

  assign clr = (reg_we_i && reg_addr_i == A_FLAGS) ? reg_wdata_i[W-1:0] : '0;

  cs_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .det_i(det), .clr_i(clr), .en_i(en_q),
    .flags_o(flags), .irq_o(irq_o)
  );

  cs_decode u_dec (
    .clk(clk), .rst_n(rst_n), .io_mode_i(io_mode_i),
    .wp_lvl_i(lvl[P_WP]), .cd_a_lvl_i(lvl[P_CDA]), .cd_b_lvl_i(lvl[P_CDB]),
    .bv1_lvl_i(lvl[P_BV1]), .bv1_det_i(det[P_BV1]), .bv2_lvl_i(lvl[P_BV2]),
    .card_present_o(card_present_o), .write_prot_o(write_prot_o),
    .batt_state_o(batt), .stschg_o(stschg_o), .stschg_evt_o(stschg_evt_o)
  );
  assign batt_state_o = batt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      xsel_q <= EDGE_BOTH;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_ENABLE) en_q <= reg_wdata_i[W-1:0];
      if (reg_addr_i == A_EDGE)   xsel_q <= edge_sel_e'(reg_wdata_i[SELW-1:0]);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_STATUS: reg_rdata_o[LVL_LSB +: W] = lvl;
      A_FLAGS:  reg_rdata_o[W-1:0] = flags;
      A_ENABLE: reg_rdata_o[W-1:0] = en_q;
      default:  reg_rdata_o[SELW-1:0] = xsel_q;
    endcase
  end

  // R5: the interrupt can only drop after software touched a register
  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(reg_we_i));
endmodule

// File: tb/sim_card_stat_port.sv
module sim_card_stat_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pins = 8'hA5;
  logic io_mode = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, cpres, wprot, schg, schg_evt;
  logic [1:0] batt;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  card_stat_port u0 (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .io_mode_i(io_mode),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .card_present_o(cpres), .write_prot_o(wprot),
    .batt_state_o(batt), .stschg_o(schg), .stschg_evt_o(schg_evt)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [7:0] exp_det(input logic [7:0] o, input logic [7:0] n,
                                         input logic [1:0] sel);
    logic [7:0] r;
    r = o ^ n;
    if (sel == 2'd1) r[7] = n[7] & ~o[7];
    if (sel == 2'd2) r[7] = ~n[7] & o[7];
    return r;
  endfunction

  function automatic logic [1:0] exp_batt(input logic [7:0] p, input logic io);
    if (io) return 2'd3;
    if (p[5]) return 2'd2;
    if (p[6]) return 2'd1;
    return 2'd0;
  endfunction

  task automatic check_outputs(input logic [7:0] p, input logic [7:0] fl, input logic [7:0] en);
    logic [31:0] d;
    rd(2'd0, d); chk("R1 status", d, {8'h00, p, 16'h0000});
    rd(2'd1, d); chk("R2 flags", d, {24'h0, fl});
    chk("R5 irq", {31'b0, irq}, {31'b0, |(fl & en)});
    chk("R7 card present", {31'b0, cpres}, {31'b0, ~p[3] & ~p[4]});
    chk("R8 battery", {30'b0, batt}, {30'b0, exp_batt(p, io_mode)});
    chk("R9 stschg level", {31'b0, schg}, {31'b0, io_mode & ~p[5]});
    chk("R10 write protect", {31'b0, wprot}, {31'b0, p[2]});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [7:0] cur, nxt, exp_fl, en, mask;
    logic [1:0] sel;
    logic [31:0] d;
    void'($urandom(32'h1234_5678));

    // R6: pins move during reset, preload must leave no flags
    repeat (2) @(negedge clk);
    pins = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur = 8'h5A; exp_fl = '0; en = '0; sel = 2'd0;
    repeat (3) @(negedge clk);
    rd(2'd1, d); chk("R6 flags after reset", d, 32'h0);
    rd(2'd2, d); chk("R6 enables after reset", d, 32'h0);
    rd(2'd3, d); chk("R6 edge select after reset", d, 32'h0);
    chk("R6 irq after reset", {31'b0, irq}, 32'h0);
    check_outputs(cur, exp_fl, en);

    // R1: write to status has no effect
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R1 status write ignored", d, {8'h00, cur, 16'h0});

    // R1 latency: level visible after second rising edge
    pins = 8'h5B;
    @(negedge clk);
    rd(2'd0, d); chk("R1 not yet visible", d, {8'h00, 8'h5A, 16'h0});
    @(negedge clk);
    rd(2'd0, d); chk("R1 visible after two edges", d, {8'h00, 8'h5B, 16'h0});
    @(negedge clk);
    rd(2'd1, d); chk("R2 flag after third edge", d, 32'h1);
    cur = 8'h5B; exp_fl = 8'h01;

    // R3: clear colliding with a new edge on the same line keeps the flag
    pins = 8'h5A;
    repeat (2) @(negedge clk);
    wr(2'd1, 32'h1);
    rd(2'd1, d); chk("R3 set wins over clear", d, 32'h1);
    cur = 8'h5A;
    repeat (2) @(negedge clk);
    wr(2'd1, 32'h1);
    rd(2'd1, d); chk("R3 write one clears", d, 32'h0);
    exp_fl = '0;

    // R5: irq follows enable, falls after clear
    en = 8'h04; wr(2'd2, {24'h0, en});
    pins = cur ^ 8'h04;
    repeat (4) @(negedge clk);
    cur = cur ^ 8'h04; exp_fl = 8'h04;
    chk("R5 irq raised", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h04); exp_fl = '0;
    chk("R5 irq dropped after clear", {31'b0, irq}, 32'h0);

    // R9: status-change pulse in I/O mode
    io_mode = 1'b1;
    pins = cur | 8'h20;
    repeat (4) @(negedge clk);
    cur = cur | 8'h20;
    rd(2'd1, d); exp_fl = d[7:0];
    pins = cur & ~8'h20;
    @(negedge clk);
    chk("R9 no event before sync", {31'b0, schg_evt}, 32'h0);
    @(negedge clk);
    chk("R9 event pulse", {31'b0, schg_evt}, 32'h1);
    @(negedge clk);
    chk("R9 event single cycle", {31'b0, schg_evt}, 32'h0);
    @(negedge clk);
    cur = cur & ~8'h20; exp_fl = exp_fl | 8'h20;
    check_outputs(cur, exp_fl, en);

    // random traffic (R2 R3 R4 R5 R7 R8 R9 R10)
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        mask = 8'($urandom); wr(2'd1, {24'h0, mask}); exp_fl &= ~mask;
      end
      if ($urandom_range(0, 5) == 0) begin
        en = 8'($urandom); wr(2'd2, {24'h0, en});
      end
      if ($urandom_range(0, 5) == 0) begin
        sel = 2'($urandom); wr(2'd3, {30'h0, sel});
        rd(2'd3, d); chk("R4 edge select readback", d, {30'h0, sel});
      end
      if ($urandom_range(0, 7) == 0) io_mode = ~io_mode;
      nxt = ($urandom_range(0, 1) == 0) ? 8'($urandom) : (cur ^ 8'h80);
      pins = nxt;
      repeat (4) @(negedge clk);
      exp_fl |= exp_det(cur, nxt, sel);
      cur = nxt;
      check_outputs(cur, exp_fl, en);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule